// File: doc/BRIEF.md
# Two-Entry Receive Character Buffer

The block sits between a serial receiver's shift register and the processor. It holds up to two received characters in arrival order. Each stored entry keeps its own low data byte, its ninth data bit, a frame-error bit, a parity-error bit and an overrun bit. The head entry is always presented at the outputs, and a receive-complete flag shows that unread data is waiting. A read strobe from the processor consumes the head entry. The ninth bit and the flags of that character must therefore be sampled before the strobe is given, because they describe the head entry only.

The receiver signals `shifter_full` while a finished character sits in its shift register. The block answers with `shifter_taken` in the cycle it copies that character in. If both entries are occupied, a character is still waiting in the shift register and a new start bit is detected, the block records an overrun. The overrun bit is attached to the waiting character when it finally enters the buffer, and it leaves together with that entry. Clearing the receiver enable empties the buffer and drops every flag.

Occupancy is a three-state machine with the states FILL_EMPTY, FILL_ONE and FILL_TWO. These are its transitions:
- FIRST: FILL_EMPTY to FILL_ONE on a take.
- SECOND: FILL_ONE to FILL_TWO on a take without a read.
- REPLACE: FILL_ONE to FILL_ONE on a take together with a read.
- DRAIN: FILL_ONE to FILL_EMPTY on a read without a take.
- STREAM: FILL_TWO to FILL_TWO on a take together with a read.
- RELEASE: FILL_TWO to FILL_ONE on a read without a take.
- FLUSH: any state to FILL_EMPTY while the enable is low.

Top module: `rx_char_fifo`

## Requirements
- R1: Characters leave in the order they were taken, and the oldest unread one is always shown on the head outputs one cycle after the edge that took it or exposed it.
- R2: `rx_complete` is 1 exactly when at least one unread entry is held.
- R3: A `pop` at a clock edge removes the head entry. A `pop` while the buffer is empty changes nothing.
- R4: Frame-error and parity-error are stored per entry and shown for the head entry only. The parity error is stored only if `parity_check_en` was 1 when the character was taken.
- R5: With both entries held, `shifter_full` high, `start_detect` high and no `pop`, an overrun is recorded. The next character taken carries `head_overrun`=1 while it is the head, and the bit clears when that entry is popped.
- R6: While `rx_enable` is 0 nothing is taken. One edge later the buffer is empty with all flags at 0, and any recorded but unattached overrun is discarded.
- R7: `size_code` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3, and nine bits for code 4. Codes 5 to 7 act as 8 bits. Data bits above the selected size are stored as 0. The ninth bit is stored only for code 4 and is 0 otherwise.
- R8: `shifter_taken` is 1 when `rx_enable` and `shifter_full` are 1 and the buffer is not full, or when it is full and `pop` is 1 in the same cycle. A take and a read on a full buffer are both honoured, and the buffer stays at two entries.
- R9: While the buffer is empty, every head output is 0.
- R10: After reset the buffer is empty, every output is 0, and it returns to that state whenever reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receiver enable; 0 flushes the buffer |
| shifter_full | input | 1 | A complete character waits in the shift register |
| start_detect | input | 1 | A new start bit was detected this cycle |
| in_data | input | 8 | Low data bits of the waiting character |
| in_bit8 | input | 1 | Ninth data bit of the waiting character |
| in_frame_err | input | 1 | First stop bit of the waiting character was 0 |
| in_parity_err | input | 1 | Parity mismatch of the waiting character |
| parity_check_en | input | 1 | Parity checking enabled at arrival |
| size_code | input | 3 | Character size code |
| pop | input | 1 | Read strobe that consumes the head entry |
| shifter_taken | output | 1 | The waiting character is copied in this cycle |
| rx_complete | output | 1 | Unread data present |
| head_data | output | 8 | Low data bits of the head entry |
| head_bit8 | output | 1 | Ninth bit of the head entry |
| head_frame_err | output | 1 | Frame error of the head entry |
| head_parity_err | output | 1 | Parity error of the head entry |
| head_overrun | output | 1 | Overrun preceded the head entry |

## Verification
The bench drives a full buffer with a character held in the shift register and a start bit. It checks that the overrun lands on the later entry and not on the current head; a design that flagged the head, or flagged nothing, would show the wrong bit one read too early or never. It streams takes and reads on a full buffer to catch a design that drops the incoming character or loses order. It also pops an empty buffer, flushes with an overrun still pending, and takes characters of every size to expose stale upper bits or a leaking ninth bit. Each of these errors would show up as a wrong head value or flag.

// File: rtl/rx_char_fifo_pkg.sv
package rx_char_fifo_pkg;
    localparam int CHAR_W   = 8;
    localparam int SIZE_W   = 3;
    localparam int MIN_BITS = 5;
    localparam logic [SIZE_W-1:0] SIZE_NINE = SIZE_W'(4);

    typedef enum logic [1:0] {
        FILL_EMPTY,
        FILL_ONE,
        FILL_TWO
    } fill_state_t;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              bit8;
        logic              frame_err;
        logic              parity_err;
        logic              overrun;
    } rx_entry_t;

    // Keep-mask for the low data bits: codes below SIZE_NINE give MIN_BITS+code bits.
    function automatic logic [CHAR_W-1:0] keep_mask(input logic [SIZE_W-1:0] code);
        logic [CHAR_W-1:0] m;
        int                n;
        n = (code < SIZE_NINE) ? (MIN_BITS + int'(code)) : CHAR_W;
        for (int i = 0; i < CHAR_W; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction
endpackage

// File: rtl/rx_char_pack.sv
module rx_char_pack
    import rx_char_fifo_pkg::*;
(
    input  logic [CHAR_W-1:0] in_data,
    input  logic              in_bit8,
    input  logic              in_frame_err,
    input  logic              in_parity_err,
    input  logic              parity_check_en,
    input  logic [SIZE_W-1:0] size_code,
    input  logic              ovr_flag,
    output rx_entry_t         entry
);
    always_comb begin
        entry.data       = in_data & keep_mask(size_code);
        entry.bit8       = (size_code == SIZE_NINE) && in_bit8;
        entry.frame_err  = in_frame_err;
        entry.parity_err = in_parity_err && parity_check_en;
        entry.overrun    = ovr_flag;
    end
endmodule

// File: rtl/rx_overrun_track.sv
module rx_overrun_track (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_enable,
    input  logic buffer_full,
    input  logic pop,
    input  logic shifter_full,
    input  logic start_detect,
    input  logic taken,
    output logic ovr_pending
);
    // Pending overrun waits for the shifter character, then rides into its entry.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_pending <= 1'b0;
        end else if (!rx_enable || taken) begin
            ovr_pending <= 1'b0;
        end else if (buffer_full && !pop && shifter_full && start_detect) begin
            ovr_pending <= 1'b1;
        end
    end
endmodule

// File: rtl/rx_fifo_core.sv
module rx_fifo_core
    import rx_char_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_enable,
    input  logic        push,
    input  logic        pop,
    input  rx_entry_t   entry_in,
    output fill_state_t state,
    output rx_entry_t   head
);
    fill_state_t state_q, state_d;
    rx_entry_t   slot0_q, slot1_q;
    logic        load0, load1, shift;

    always_comb begin
        state_d = state_q;
        load0   = 1'b0;
        load1   = 1'b0;
        shift   = 1'b0;
        if (!rx_enable) begin
            state_d = FILL_EMPTY;                       // FLUSH
        end else begin
            unique case (state_q)
                FILL_EMPTY: begin
                    if (push) begin                     // FIRST
                        load0   = 1'b1;
                        state_d = FILL_ONE;
                    end
                end
                FILL_ONE: begin
                    if (push && pop) begin              // REPLACE
                        load0 = 1'b1;
                    end else if (push) begin            // SECOND
                        load1   = 1'b1;
                        state_d = FILL_TWO;
                    end else if (pop) begin             // DRAIN
                        state_d = FILL_EMPTY;
                    end
                end
                FILL_TWO: begin
                    if (pop) begin
                        shift = 1'b1;
                        if (push) begin                 // STREAM
                            load1 = 1'b1;
                        end else begin                  // RELEASE
                            state_d = FILL_ONE;
                        end
                    end
                end
                default: state_d = FILL_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot0_q <= '0;
            slot1_q <= '0;
        end else if (!rx_enable) begin
            slot0_q <= '0;
            slot1_q <= '0;
        end else begin
            if (load0) begin
                slot0_q <= entry_in;
            end else if (shift) begin
                slot0_q <= slot1_q;
            end
            if (load1) begin
                slot1_q <= entry_in;
            end
        end
    end

    assign state = state_q;
    assign head  = slot0_q;
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
    import rx_char_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              shifter_full,
    input  logic              start_detect,
    input  logic [CHAR_W-1:0] in_data,
    input  logic              in_bit8,
    input  logic              in_frame_err,
    input  logic              in_parity_err,
    input  logic              parity_check_en,
    input  logic [SIZE_W-1:0] size_code,
    input  logic              pop,
    output logic              shifter_taken,
    output logic              rx_complete,
    output logic [CHAR_W-1:0] head_data,
    output logic              head_bit8,
    output logic              head_frame_err,
    output logic              head_parity_err,
    output logic              head_overrun
);
    fill_state_t state;
    rx_entry_t   entry_in, head;
    logic        ovr_pending;
    logic        take;

    assign take = rx_enable && shifter_full && ((state != FILL_TWO) || pop);

    rx_char_pack u_pack (
        .in_data         (in_data),
        .in_bit8         (in_bit8),
        .in_frame_err    (in_frame_err),
        .in_parity_err   (in_parity_err),
        .parity_check_en (parity_check_en),
        .size_code       (size_code),
        .ovr_flag        (ovr_pending),
        .entry           (entry_in)
    );

    rx_overrun_track u_ovr (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_enable    (rx_enable),
        .buffer_full  (state == FILL_TWO),
        .pop          (pop),
        .shifter_full (shifter_full),
        .start_detect (start_detect),
        .taken        (take),
        .ovr_pending  (ovr_pending)
    );

    rx_fifo_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_enable (rx_enable),
        .push      (take),
        .pop       (pop),
        .entry_in  (entry_in),
        .state     (state),
        .head      (head)
    );

    // Output process: head fields are gated to zero while empty.
    always_comb begin
        shifter_taken   = take;
        rx_complete     = (state != FILL_EMPTY);
        head_data       = rx_complete ? head.data : '0;
        head_bit8       = rx_complete && head.bit8;
        head_frame_err  = rx_complete && head.frame_err;
        head_parity_err = rx_complete && head.parity_err;
        head_overrun    = rx_complete && head.overrun;
    end
endmodule

// File: rtl/rx_char_fifo_checker.sv
module rx_char_fifo_checker
    import rx_char_fifo_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rx_enable,
    input logic              shifter_full,
    input logic [SIZE_W-1:0] size_code,
    input logic              pop,
    input logic              shifter_taken,
    input logic              rx_complete,
    input logic [CHAR_W-1:0] head_data,
    input logic              head_bit8,
    input logic              head_frame_err,
    input logic              head_parity_err,
    input logic              head_overrun
);
    // Occupancy seen from the ports only.
    logic [1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= 2'd0;
        end else if (!rx_enable) begin
            cnt <= 2'd0;
        end else begin
            cnt <= cnt + {1'b0, shifter_taken} - {1'b0, (pop && (cnt != 2'd0))};
        end
    end

    assert_rxc_tracks_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_complete == (cnt != 2'd0));

    assert_pop_last_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && cnt == 2'd1 && pop && !shifter_taken) |=> !rx_complete);

    assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> (!rx_complete && !head_overrun));

    assert_bit8_only_nine_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (shifter_taken && (cnt == 2'd0 || (cnt == 2'd1 && pop)) && size_code != SIZE_NINE)
        |=> !head_bit8);

    assert_no_take_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == 2'd2 && !pop) |-> !shifter_taken);

    assert_take_needs_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shifter_taken |-> (shifter_full && rx_enable));

    assert_empty_outputs_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_complete |-> (head_data == '0 && !head_bit8 && !head_frame_err
                          && !head_parity_err && !head_overrun));
endmodule

bind rx_char_fifo rx_char_fifo_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .rx_enable       (rx_enable),
    .shifter_full    (shifter_full),
    .size_code       (size_code),
    .pop             (pop),
    .shifter_taken   (shifter_taken),
    .rx_complete     (rx_complete),
    .head_data       (head_data),
    .head_bit8       (head_bit8),
    .head_frame_err  (head_frame_err),
    .head_parity_err (head_parity_err),
    .head_overrun    (head_overrun)
);

// File: tb/rx_char_fifo_bench.sv
module rx_char_fifo_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_enable, shifter_full, start_detect;
    logic [7:0] in_data;
    logic       in_bit8, in_frame_err, in_parity_err, parity_check_en;
    logic [2:0] size_code;
    logic       pop;
    logic       shifter_taken, rx_complete;
    logic [7:0] head_data;
    logic       head_bit8, head_frame_err, head_parity_err, head_overrun;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_char_fifo u_rx_char_fifo (
        .clk (clk), .rst_n (rst_n), .rx_enable (rx_enable),
        .shifter_full (shifter_full), .start_detect (start_detect),
        .in_data (in_data), .in_bit8 (in_bit8), .in_frame_err (in_frame_err),
        .in_parity_err (in_parity_err), .parity_check_en (parity_check_en),
        .size_code (size_code), .pop (pop), .shifter_taken (shifter_taken),
        .rx_complete (rx_complete), .head_data (head_data), .head_bit8 (head_bit8),
        .head_frame_err (head_frame_err), .head_parity_err (head_parity_err),
        .head_overrun (head_overrun)
    );

    typedef struct packed {
        bit       en, sf, st, pp;
        bit [2:0] sz;
        bit       pen;
        bit [8:0] d9;
        bit       fe, pe;
        bit       tk;
        bit       rxc;
        bit [7:0] hd;
        bit       hb8, hfe, hpe, hov;
        bit [3:0] req;
    } vec_t;

    // en sf st pop sz pen d9 fe pe | taken rxc head b8 fe pe ovr | req
    localparam vec_t VECS [NVEC] = '{
        '{1,1,0,0,3'd3,0,9'h0A5,0,0, 1,1,8'hA5,0,0,0,0, 4'd1},  // R1 first take
        '{1,1,0,0,3'd0,0,9'h13C,1,0, 1,1,8'hA5,0,0,0,0, 4'd1},  // R1 head unchanged
        '{1,1,0,0,3'd3,0,9'h077,0,0, 0,1,8'hA5,0,0,0,0, 4'd8},  // R8 full, no take
        '{1,1,1,0,3'd3,0,9'h077,0,0, 0,1,8'hA5,0,0,0,0, 4'd5},  // R5 overrun seen, head clean
        '{1,1,0,1,3'd3,0,9'h077,0,0, 1,1,8'h1C,0,1,0,0, 4'd7},  // R7 5-bit mask, R4 fe
        '{1,0,0,1,3'd3,0,9'h000,0,0, 0,1,8'h77,0,0,0,1, 4'd5},  // R5 overrun on entry
        '{1,0,0,1,3'd3,0,9'h000,0,0, 0,0,8'h00,0,0,0,0, 4'd3},  // R3 pop last
        '{1,0,0,1,3'd3,0,9'h000,0,0, 0,0,8'h00,0,0,0,0, 4'd3},  // R3 pop on empty
        '{1,1,0,0,3'd4,1,9'h1F0,0,1, 1,1,8'hF0,1,0,1,0, 4'd4},  // R4 pe recorded, 9-bit
        '{1,1,0,0,3'd3,0,9'h1FF,0,1, 1,1,8'hF0,1,0,1,0, 4'd4},  // R4 second entry
        '{1,1,0,1,3'd2,0,9'h0D5,0,0, 1,1,8'hFF,0,0,0,0, 4'd7},  // R7 bit8 dropped, pe off
        '{0,1,0,0,3'd3,0,9'h011,0,0, 0,0,8'h00,0,0,0,0, 4'd6},  // R6 flush
        '{1,0,0,0,3'd3,0,9'h000,0,0, 0,0,8'h00,0,0,0,0, 4'd9},  // R9 empty zeros
        '{1,1,1,1,3'd1,0,9'h0F1,0,0, 1,1,8'h31,0,0,0,0, 4'd7},  // R7 6-bit, pop empty
        '{1,1,0,1,3'd3,0,9'h042,0,0, 1,1,8'h42,0,0,0,0, 4'd8},  // R8 take+read at one
        '{1,0,0,1,3'd3,0,9'h000,0,0, 0,0,8'h00,0,0,0,0, 4'd2}   // R2 empty again
    };

    function automatic string req_name(input bit [3:0] r);
        case (r)
            4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
            4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
            4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input bit en, input bit sf, input bit st, input bit pp,
                         input bit [2:0] sz, input bit pen, input bit [8:0] d9,
                         input bit fe, input bit pe);
        rx_enable = en; shifter_full = sf; start_detect = st; pop = pp;
        size_code = sz; parity_check_en = pen; in_data = d9[7:0]; in_bit8 = d9[8];
        in_frame_err = fe; in_parity_err = pe;
    endtask

    function automatic logic [12:0] outs();
        return {rx_complete, head_data, head_bit8, head_frame_err,
                head_parity_err, head_overrun};
    endfunction

    task automatic step(input bit en, input bit sf, input bit pp, input bit [7:0] d);
        drive(en, sf, 1'b0, pp, 3'd3, 1'b0, {1'b0, d}, 1'b0, 1'b0);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 3'd3, 0, 9'h0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R10", "reset outputs", {19'd0, outs()}, 32'd0);
        chk("R10", "reset take", {31'd0, shifter_taken}, 32'd0);
        rst_n = 1'b1;

        // Table walk: inputs at negedge, take checked before the edge, outputs after.
        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].en, VECS[i].sf, VECS[i].st, VECS[i].pp, VECS[i].sz,
                  VECS[i].pen, VECS[i].d9, VECS[i].fe, VECS[i].pe);
            #1;
            chk(req_name(VECS[i].req), $sformatf("vector %0d take", i),
                {31'd0, shifter_taken}, {31'd0, VECS[i].tk});
            @(negedge clk);
            chk(req_name(VECS[i].req), $sformatf("vector %0d head", i),
                {19'd0, outs()},
                {19'd0, VECS[i].rxc, VECS[i].hd, VECS[i].hb8, VECS[i].hfe,
                 VECS[i].hpe, VECS[i].hov});
        end

        // R6: pending overrun discarded by a flush.
        step(1, 1, 0, 8'h0A);
        step(1, 1, 0, 8'h0B);
        drive(1, 1, 1, 0, 3'd3, 0, 9'h00C, 0, 0);
        @(negedge clk);
        step(0, 1, 0, 8'h0C);
        step(1, 1, 0, 8'h0D);
        chk("R6", "overrun after flush", {23'd0, head_data, head_overrun}, {23'd0, 8'h0D, 1'b0});

        // R8 / R1: streaming on a full buffer keeps order.
        step(1, 0, 1, 8'h00);
        step(1, 1, 0, 8'h10);
        step(1, 1, 0, 8'h20);
        chk("R1", "full head", {24'd0, head_data}, 32'h10);
        step(1, 1, 1, 8'h30);
        chk("R8", "stream 1", {24'd0, head_data}, 32'h20);
        step(1, 1, 1, 8'h40);
        chk("R8", "stream 2", {24'd0, head_data}, 32'h30);
        step(1, 0, 1, 8'h00);
        chk("R1", "after release", {23'd0, rx_complete, head_data}, {23'd0, 1'b1, 8'h40});
        step(1, 0, 1, 8'h00);
        chk("R2", "drained", {31'd0, rx_complete}, 32'd0);

        // R10: reset while holding data.
        step(1, 1, 0, 8'h55);
        rst_n = 1'b0;
        drive(1, 0, 0, 0, 3'd3, 0, 9'h0, 0, 0);
        #1;
        chk("R10", "mid-run reset", {19'd0, outs()}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "after reset release", {19'd0, outs()}, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule